// File: doc/BRIEF.md
# Radix-2 Frequency-Split Butterfly with Twiddle Rotation

This block performs one radix-2 decimation-in-frequency butterfly for a single FFT stage. Each valid cycle it accepts two complex samples, `x` and `y`, together with one complex twiddle weight. It returns two complex results. The upper result is the plain sum `x+y`. The lower result is the difference `x-y`, rotated by the twiddle and scaled back to the sample width.

The weights are normalized, so a value of 2^15 stands for unity. The difference path keeps the full product and then drops the low `WEIGHT_W-1` bits. The sum path passes through a delay line so that both results leave in the same cycle, flagged by one output valid. The block accepts a new sample pair on every cycle. It has no backpressure. The surrounding stage normally holds the weight constant for a given stage and element position, but the block captures the weight together with each sample, so the weight may also change from one sample to the next.

Top module: `dif_butterfly_r2`

## Requirements
- R1: `sum_re`/`sum_im` equal `x+y`, computed per component in 16-bit two's complement and wrapping on overflow (for example 32767+1 gives -32768).
- R2: The difference `d = x-y` is formed per component in 16-bit two's complement with wrap. The rotation is non-conjugated and uses full signed precision: real part `d_re*w_re - d_im*w_im`, imaginary part `d_re*w_im + d_im*w_re`.
- R3: Each full product component is truncated by discarding its 15 least significant bits (floor, no rounding). The output takes bits 30 down to 15 of the product, with no saturation.
- R4: A sample pair captured with `in_valid` high appears on the outputs with `out_valid` high exactly 4 clock cycles later (1 butterfly stage plus 3 multiplier stages). The sum and the rotated difference of the same pair appear in the same cycle.
- R5: The weight is sampled in the same cycle as its sample pair. A different weight on the next cycle affects only the next pair.
- R6: A synchronous active-high `rst` clears every sample in flight. `out_valid` is low in the cycle after any reset cycle and stays low until a sample captured after reset has had its 4 cycles of latency.
- R7: Pairs presented on consecutive cycles are all processed and come out on consecutive cycles in input order.
- R8: Cycles with `in_valid` low produce no output. The gaps in `out_valid` repeat the input gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid |
| x_re | input | 16 | Upper input, real part (signed) |
| x_im | input | 16 | Upper input, imaginary part (signed) |
| y_re | input | 16 | Lower input, real part (signed) |
| y_im | input | 16 | Lower input, imaginary part (signed) |
| w_re | input | 16 | Twiddle real part, 2^15 means unity (signed) |
| w_im | input | 16 | Twiddle imaginary part (signed) |
| sum_re | output | 16 | Sum output, real part |
| sum_im | output | 16 | Sum output, imaginary part |
| dif_re | output | 16 | Rotated difference output, real part |
| dif_im | output | 16 | Rotated difference output, imaginary part |
| out_valid | output | 1 | Output valid |

## Verification
On every cycle the assertions check several properties. They check that `out_valid` follows an independent 4-deep record of `in_valid`, which covers R4 and R8. They check that reset empties the pipeline, and that each valid output carries the wrapped sum and the floor-truncated rotation of the pair captured 4 cycles earlier, each compared against its own delayed reference. Other properties can only be shown by the bench's scenarios. These are the wrap corners at the extremes of the range, a weight that changes on every sample in a back-to-back burst, input gaps reproduced at the output, and a reset asserted while samples are in flight.

// File: rtl/dif_butterfly_r2.sv
module dif_butterfly_r2 #(
  parameter int DATA_W   = 16,
  parameter int WEIGHT_W = 16,
  parameter int GROWTH   = 1,
  parameter int BF_LAT   = 1,
  parameter int MUL_LAT  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0]   x_re,
  input  logic signed [DATA_W-1:0]   x_im,
  input  logic signed [DATA_W-1:0]   y_re,
  input  logic signed [DATA_W-1:0]   y_im,
  input  logic signed [WEIGHT_W-1:0] w_re,
  input  logic signed [WEIGHT_W-1:0] w_im,
  output logic signed [DATA_W-1:0]   sum_re,
  output logic signed [DATA_W-1:0]   sum_im,
  output logic signed [DATA_W-1:0]   dif_re,
  output logic signed [DATA_W-1:0]   dif_im,
  output logic                     out_valid
);
  localparam int TOT_LAT = BF_LAT + MUL_LAT;
  localparam int SHIFT   = WEIGHT_W - GROWTH;
  localparam int PROD_W  = DATA_W + WEIGHT_W + 1;

  logic [TOT_LAT-1:0] vld_q;
  logic signed [DATA_W-1:0]   s_re_q [TOT_LAT];
  logic signed [DATA_W-1:0]   s_im_q [TOT_LAT];
  logic signed [DATA_W-1:0]   d_re_q [BF_LAT];
  logic signed [DATA_W-1:0]   d_im_q [BF_LAT];
  logic signed [WEIGHT_W-1:0] wr_q   [BF_LAT];
  logic signed [WEIGHT_W-1:0] wi_q   [BF_LAT];
  logic signed [DATA_W-1:0]   m_re_q [MUL_LAT];
  logic signed [DATA_W-1:0]   m_im_q [MUL_LAT];

  logic signed [DATA_W-1:0] d_re_in, d_im_in;
  logic signed [PROD_W-1:0] p_re, p_im;

  assign d_re_in = x_re - y_re;
  assign d_im_in = x_im - y_im;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[TOT_LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    s_re_q[0] <= x_re + y_re;
    s_im_q[0] <= x_im + y_im;
    for (int i = 1; i < TOT_LAT; i++) begin
      s_re_q[i] <= s_re_q[i-1];
      s_im_q[i] <= s_im_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d_re_q[0] <= d_re_in;
    d_im_q[0] <= d_im_in;
    wr_q[0]   <= w_re;
    wi_q[0]   <= w_im;
    for (int i = 1; i < BF_LAT; i++) begin
      d_re_q[i] <= d_re_q[i-1];
      d_im_q[i] <= d_im_q[i-1];
      wr_q[i]   <= wr_q[i-1];
      wi_q[i]   <= wi_q[i-1];
    end
  end

  assign p_re = PROD_W'(d_re_q[BF_LAT-1]) * PROD_W'(wr_q[BF_LAT-1])
              - PROD_W'(d_im_q[BF_LAT-1]) * PROD_W'(wi_q[BF_LAT-1]);
  assign p_im = PROD_W'(d_re_q[BF_LAT-1]) * PROD_W'(wi_q[BF_LAT-1])
              + PROD_W'(d_im_q[BF_LAT-1]) * PROD_W'(wr_q[BF_LAT-1]);

  always_ff @(posedge clk) begin
    m_re_q[0] <= p_re[SHIFT +: DATA_W];
    m_im_q[0] <= p_im[SHIFT +: DATA_W];
    for (int i = 1; i < MUL_LAT; i++) begin
      m_re_q[i] <= m_re_q[i-1];
      m_im_q[i] <= m_im_q[i-1];
    end
  end

  assign sum_re    = s_re_q[TOT_LAT-1];
  assign sum_im    = s_im_q[TOT_LAT-1];
  assign dif_re    = m_re_q[MUL_LAT-1];
  assign dif_im    = m_im_q[MUL_LAT-1];
  assign out_valid = vld_q[TOT_LAT-1];
endmodule

// File: rtl/dif_butterfly_r2_chk.sv
module dif_butterfly_r2_chk #(
  parameter int DATA_W   = 16,
  parameter int WEIGHT_W = 16,
  parameter int GROWTH   = 1,
  parameter int BF_LAT   = 1,
  parameter int MUL_LAT  = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0]   x_re,
  input logic signed [DATA_W-1:0]   x_im,
  input logic signed [DATA_W-1:0]   y_re,
  input logic signed [DATA_W-1:0]   y_im,
  input logic signed [WEIGHT_W-1:0] w_re,
  input logic signed [WEIGHT_W-1:0] w_im,
  input logic signed [DATA_W-1:0]   sum_re,
  input logic signed [DATA_W-1:0]   sum_im,
  input logic signed [DATA_W-1:0]   dif_re,
  input logic signed [DATA_W-1:0]   dif_im,
  input logic                     out_valid
);
  localparam int LAT = BF_LAT + MUL_LAT;
  localparam int SH  = WEIGHT_W - GROWTH;
  localparam int PW  = DATA_W + WEIGHT_W + 1;

  logic [LAT-1:0] v_hist;
  logic [4*DATA_W-1:0] ref_q [LAT];
  logic signed [DATA_W-1:0] cd_re, cd_im;
  logic signed [PW-1:0] cp_re, cp_im;

  assign cd_re = x_re - y_re;
  assign cd_im = x_im - y_im;
  assign cp_re = PW'(cd_re) * PW'(w_re) - PW'(cd_im) * PW'(w_im);
  assign cp_im = PW'(cd_re) * PW'(w_im) + PW'(cd_im) * PW'(w_re);

  always_ff @(posedge clk) begin
    if (rst) v_hist <= '0;
    else     v_hist <= {v_hist[LAT-2:0], in_valid};
    ref_q[0] <= {DATA_W'(x_re + y_re), DATA_W'(x_im + y_im),
                 cp_re[SH +: DATA_W], cp_im[SH +: DATA_W]};
    for (int i = 1; i < LAT; i++) ref_q[i] <= ref_q[i-1];
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_hist[LAT-1]); // R4
  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !out_valid); // R6
  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> {sum_re, sum_im} == ref_q[LAT-1][4*DATA_W-1:2*DATA_W]); // R1
  AST_ROTATED_VALUE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> {dif_re, dif_im} == ref_q[LAT-1][2*DATA_W-1:0]); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !v_hist[LAT-1] |-> !out_valid); // R8
endmodule

bind dif_butterfly_r2 dif_butterfly_r2_chk #(
  .DATA_W(DATA_W), .WEIGHT_W(WEIGHT_W), .GROWTH(GROWTH),
  .BF_LAT(BF_LAT), .MUL_LAT(MUL_LAT)
) u_chk (.*);

// File: tb/tb_dif_butterfly_r2.sv
module tb_dif_butterfly_r2;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [15:0] x_re = 0, x_im = 0, y_re = 0, y_im = 0, w_re = 0, w_im = 0;
  logic signed [15:0] sum_re, sum_im, dif_re, dif_im;
  logic out_valid;

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dif_butterfly_r2 dut (.*);

  function automatic logic [63:0] model(input logic signed [15:0] xr, xi, yr, yi, wr, wi);
    logic signed [15:0] dr, di, sr, si;
    longint pr, pi;
    sr = xr + yr; si = xi + yi;
    dr = xr - yr; di = xi - yi;
    pr = longint'(dr) * longint'(wr) - longint'(di) * longint'(wi);
    pi = longint'(dr) * longint'(wi) + longint'(di) * longint'(wr);
    pr = pr >>> 15; pi = pi >>> 15;
    return {sr, si, pr[15:0], pi[15:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic signed [15:0] xr, xi, yr, yi, wr, wi);
    @(negedge clk);
    in_valid = 1; x_re = xr; x_im = xi; y_re = yr; y_im = yi; w_re = wr; w_im = wi;
    exp_q.push_back(model(xr, xi, yr, yi, wr, wi));
    cyc_q.push_back(cyc + 4);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; x_re = $urandom; y_re = $urandom; w_re = $urandom;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected output", 64'd1, 64'd0);
      else begin
        logic [63:0] e; int c; string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        check({t, " R1 sum"}, {sum_re, sum_im}, e[63:32]);
        check({t, " R2/R3 rotated difference"}, {dif_re, dif_im}, e[31:0]);
        check({t, " R4 latency"}, 64'(cyc), 64'(c));
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset holds out_valid low", 64'(out_valid), 64'd0);
    rst = 0;
    idle(2);
    check("R6 idle after reset", 64'(out_valid), 64'd0);

    // wrap corners, unity weight 2^15-1 and imaginary unit
    send("R1 wrap", 16'sd32767, -16'sd32768, 16'sd1, -16'sd1, 16'sd32767, 16'sd0);
    send("R2 conj check", 16'sd1000, 16'sd200, -16'sd500, 16'sd300, 16'sd0, 16'sd32767);
    send("R3 floor negative", -16'sd3, 16'sd0, 16'sd0, 16'sd0, 16'sd16384, 16'sd0);
    send("R3 full scale weight", -16'sd32768, -16'sd32768, 16'sd0, 16'sd0, -16'sd32768, -16'sd32768);
    idle(6);
    check("R4 queue drained", 64'(exp_q.size()), 64'd0);

    // R7/R5: back-to-back burst with a new weight every cycle
    for (int i = 0; i < 40; i++)
      send("R5 R7 burst", 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           (i % 2) ? 16'sd23170 : -16'sd23170, (i % 3) ? 16'sd12540 : 16'sd30274);
    // R8: gaps
    for (int i = 0; i < 20; i++) begin
      send("R8 gapped", 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom), 16'($urandom));
      idle(i % 4);
    end
    idle(6);
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);

    // R6: reset with samples in flight
    send("R6 pre", 16'sd5, 16'sd6, 16'sd7, 16'sd8, 16'sd100, 16'sd0);
    send("R6 pre", 16'sd9, 16'sd1, 16'sd2, 16'sd3, 16'sd100, 16'sd0);
    @(negedge clk);
    in_valid = 0; rst = 1;
    exp_q.delete(); cyc_q.delete(); tag_q.delete();
    @(negedge clk);
    check("R6 flushed during reset", 64'(out_valid), 64'd0);
    rst = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R6 no stale output", 64'(out_valid), 64'd0);
    end
    send("R6 post", 16'sd100, -16'sd100, 16'sd50, 16'sd25, 16'sd32767, 16'sd0);
    idle(6);
    check("R6 post drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule